// File: doc/BRIEF.md
# PWM Fault and Output Conditioning Stage

This block is the last stage of logic between a bank of PWM generators and the device pins. Each generator delivers a pair of raw PWM waveforms, called A and B. The block brings in a set of asynchronous external fault lines and synchronizes them. For each generator it combines the lines that the generator's source mask selects into one fault condition. It also records which lines caused the fault and can raise an interrupt.

While its generator is faulted, each output either keeps its generated waveform or is overridden with a programmed safe level. A single pin-enable mask then gates every output, so one register write can move drive from one set of motor phases to another without touching the generators. A per-output polarity inversion is applied last. Every output pin is registered.

Configuration uses a simple write port: write enable, address and data. Output index 2g carries generator g's A signal and index 2g+1 carries its B signal.

Top module: `pwm_fault_cond`

## Requirements
- R1: Writes to address 0 set the pin-enable mask, with bit i for output i. A disabled output presents logic 0 before the inversion stage.
- R2: Writes to address 1 set the inversion mask. When bit i is set, output i is complemented as the final stage. This also applies to disabled and forced outputs.
- R3: A change on a raw PWM input appears at its pin exactly one clock edge later.
- R4: Writes to address 8+g set generator g's fault source mask, with bit j for fault line j. The generator's fault condition is the OR of its selected synchronized lines. Lines that are not selected have no effect on that generator.
- R5: Writes to address 2 set the fault mode bits and writes to address 3 set the fault value bits, with bit i for output i. While output i's generator is faulted, a mode bit of 1 drives the fault value bit and a mode bit of 0 keeps passing the PWM signal.
- R6: Each fault line passes through two synchronizing flops. An input change affects the pins and the status on the third rising edge after it is applied.
- R7: Generator g's status has one sticky bit per fault line, visible on fault_sts[g*NUM_FLT+j]. A bit is set when that line is selected and active. Writing 1 to it at address 16+g clears it, but a fault that is still active wins over the clear.
- R8: Writes to address 4 set the interrupt enable, with bit g for generator g. irq is the OR of enabled generators that have any status bit set, and it is registered one edge after the status.
- R9: After a synchronous reset, all configuration and status are zero, and all pins and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | DATA_W | Write data |
| flt_in | input | NUM_FLT | Asynchronous external fault lines, active high |
| pwm_raw | input | 2*NUM_GEN | Raw generator outputs (index 2g = A, 2g+1 = B) |
| pwm_pin | output | 2*NUM_GEN | Conditioned, registered pin drive |
| fault_sts | output | NUM_GEN*NUM_FLT | Sticky per-generator fault status |
| irq | output | 1 | Fault interrupt |

## Verification
A wrong mask or inversion bit shows up on the affected pin on the very next edge, because every pin is one register away from its inputs. A broken synchronizer depth or combining mask shifts the edge on which a forced safe level and a status bit appear, or makes them appear on the wrong generator, starting on the third edge after a fault line moves. Faulty sticky or clear logic shows up as a status bit that drops while a fault persists or that survives a clear, and irq follows it one edge later.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int ADDR_W       = 5;
  localparam logic [ADDR_W-1:0] A_OUT_EN  = 5'd0;
  localparam logic [ADDR_W-1:0] A_OUT_INV = 5'd1;
  localparam logic [ADDR_W-1:0] A_FMODE   = 5'd2;
  localparam logic [ADDR_W-1:0] A_FVAL    = 5'd3;
  localparam logic [ADDR_W-1:0] A_INT_EN  = 5'd4;
  localparam logic [ADDR_W-1:0] A_SRC_BASE = 5'd8;
  localparam logic [ADDR_W-1:0] A_CLR_BASE = 5'd16;
endpackage

// File: rtl/pwm_flt_sync.sv
module pwm_flt_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/pwm_flt_gen.sv
module pwm_flt_gen #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] flt_sync,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [NF-1:0] wdata,
  output logic          fault,
  output logic [NF-1:0] sts
);
  logic [NF-1:0] src_mask;
  logic [NF-1:0] hit;

  assign hit   = flt_sync & src_mask;
  assign fault = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_mask <= '0;
      sts      <= '0;
    end else begin
      if (mask_we) src_mask <= wdata;
      sts <= (sts & ~(clr_we ? wdata : '0)) | hit;
    end
  end

  // R7: a set status bit survives any cycle without a clear write
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_we) && $past(sts) != '0) |-> ((sts & $past(sts)) == $past(sts)));
  // R4: a status bit rises only for a selected, active synchronized line
  a_r4_masked_set: assert property (@(posedge clk) disable iff (rst)
    ((sts & ~$past(sts)) & ~($past(flt_sync) & $past(src_mask))) == '0);
endmodule

// File: rtl/pwm_out_cell.sv
module pwm_out_cell (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic fault,
  input  logic fmode,
  input  logic fval,
  input  logic en,
  input  logic inv,
  output logic pin
);
  logic sel;
  assign sel = (fault && fmode) ? fval : raw;

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= (sel & en) ^ inv;
  end

  // R1: disabled output shows only the inversion level
  a_r1_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (pin == $past(inv)));
  // R5: forced output shows the fault value through the inversion
  a_r5_forced: assert property (@(posedge clk) disable iff (rst)
    ($past(fault) && $past(fmode) && $past(en)) |-> (pin == ($past(fval) ^ $past(inv))));
  // R3: passing output follows its raw input one edge later
  a_r3_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(fault) && $past(en)) |-> (pin == ($past(raw) ^ $past(inv))));
endmodule

// File: rtl/pwm_fault_cond.sv
module pwm_fault_cond
  import pwm_fault_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int NUM_FLT = 4,
  parameter int NUM_OUT = 2 * NUM_GEN,
  parameter int DATA_W  = (NUM_OUT > NUM_FLT) ? NUM_OUT : NUM_FLT
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [NUM_FLT-1:0]         flt_in,
  input  logic [NUM_OUT-1:0]         pwm_raw,
  output logic [NUM_OUT-1:0]         pwm_pin,
  output logic [NUM_GEN*NUM_FLT-1:0] fault_sts,
  output logic                       irq
);
  logic [NUM_OUT-1:0] out_en, out_inv, fmode, fval;
  logic [NUM_GEN-1:0] int_en, gen_fault, gen_flag;
  logic [NUM_FLT-1:0] flt_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en  <= '0;
      out_inv <= '0;
      fmode   <= '0;
      fval    <= '0;
      int_en  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_OUT_EN:  out_en  <= wr_data[NUM_OUT-1:0];
        A_OUT_INV: out_inv <= wr_data[NUM_OUT-1:0];
        A_FMODE:   fmode   <= wr_data[NUM_OUT-1:0];
        A_FVAL:    fval    <= wr_data[NUM_OUT-1:0];
        A_INT_EN:  int_en  <= wr_data[NUM_GEN-1:0];
        default: ;
      endcase
    end
  end

  pwm_flt_sync #(.W(NUM_FLT)) u_sync (
    .clk(clk), .rst(rst), .d(flt_in), .q(flt_sync)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic [NUM_FLT-1:0] sts_g;
    pwm_flt_gen #(.NF(NUM_FLT)) u_gen (
      .clk(clk), .rst(rst), .flt_sync(flt_sync),
      .mask_we(wr_en && wr_addr == A_SRC_BASE + ADDR_W'(g)),
      .clr_we (wr_en && wr_addr == A_CLR_BASE + ADDR_W'(g)),
      .wdata(wr_data[NUM_FLT-1:0]),
      .fault(gen_fault[g]), .sts(sts_g)
    );
    assign fault_sts[g*NUM_FLT +: NUM_FLT] = sts_g;
    assign gen_flag[g] = |sts_g;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    pwm_out_cell u_cell (
      .clk(clk), .rst(rst), .raw(pwm_raw[i]), .fault(gen_fault[i/2]),
      .fmode(fmode[i]), .fval(fval[i]), .en(out_en[i]), .inv(out_inv[i]),
      .pin(pwm_pin[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(gen_flag & int_en);
  end

  // R8: irq rises only when an enabled generator held status one edge earlier
  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((fault_sts != '0) && (int_en != '0)));
  // R8: no interrupt while every generator is disabled
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    ($past(int_en) == '0) |-> !irq);
endmodule

// File: tb/pwm_fault_cond_test.sv
module pwm_fault_cond_test;
  localparam int NG = 2, NF = 4, NO = 4;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [4:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [NF-1:0] flt_in = '0;
  logic [NO-1:0] pwm_raw = '0;
  logic [NO-1:0] pwm_pin;
  logic [NG*NF-1:0] fault_sts;
  logic irq;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  pwm_fault_cond uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flt_in(flt_in), .pwm_raw(pwm_raw), .pwm_pin(pwm_pin),
    .fault_sts(fault_sts), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 pins", {28'b0, pwm_pin}, 0);
    chk("R9 irq", {31'b0, irq}, 0);
    chk("R9 status", {24'b0, fault_sts}, 0);
    rst = 0;
    @(negedge clk);
    pwm_raw = 4'hF; edges(1);
    chk("R9 R1 enable mask reset", {28'b0, pwm_pin}, 0);

    // R1 R2 R3: sweep enable, inversion and raw values
    for (int e = 0; e < 16; e++) begin
      for (int v = 0; v < 16; v++) begin
        wr(5'd0, 4'(e)); wr(5'd1, 4'(v));
        for (int p = 0; p < 16; p++) begin
          pwm_raw = 4'(p);
          edges(1);
          chk("R1 R2 R3 sweep", {28'b0, pwm_pin}, {28'b0, (4'(p) & 4'(e)) ^ 4'(v)});
        end
      end
    end

    // R3: exact one-edge latency
    wr(5'd1, 4'h0); wr(5'd0, 4'hF);
    pwm_raw = 4'h0; edges(1);
    pwm_raw = 4'hA;
    @(posedge clk); #1;
    chk("R3 latency", {28'b0, pwm_pin}, 32'hA);

    // fault setup: gen0 mask lines 0,1; gen1 mask line 2
    wr(5'd8, 4'b0011); wr(5'd9, 4'b0100);
    wr(5'd2, 4'b0101); wr(5'd3, 4'b0001);
    pwm_raw = 4'b1110; edges(1);
    chk("R5 no fault passes", {28'b0, pwm_pin}, 32'hE);

    // R4: unselected line 3 has no effect
    flt_in = 4'b1000; edges(4);
    chk("R4 unselected pins", {28'b0, pwm_pin}, 32'hE);
    chk("R4 unselected status", {24'b0, fault_sts}, 0);
    flt_in = 0; edges(3);

    // R6: line 1 raises gen0 fault on third edge
    wr(5'd4, 4'b0001);
    @(negedge clk); flt_in = 4'b0010;
    edges(2);
    chk("R6 not yet at 2 edges", {28'b0, pwm_pin}, 32'hE);
    chk("R6 status not yet", {24'b0, fault_sts}, 0);
    edges(1);
    chk("R5 R6 gen0 forced", {28'b0, pwm_pin}, 32'hF);
    chk("R7 status bit", {24'b0, fault_sts}, 32'h02);
    chk("R8 irq lags status", {31'b0, irq}, 0);
    edges(1);
    chk("R8 irq set", {31'b0, irq}, 1);

    // R7: clear while active is ignored
    wr(5'd16, 4'b0010); edges(1);
    chk("R7 set wins", {24'b0, fault_sts}, 32'h02);
    flt_in = 0; edges(4);
    chk("R7 sticky after release", {24'b0, fault_sts}, 32'h02);
    chk("R5 release restores", {28'b0, pwm_pin}, 32'hE);
    wr(5'd16, 4'b0010);
    chk("R7 cleared", {24'b0, fault_sts}, 0);
    edges(0);
    @(posedge clk); #1;
    chk("R8 irq drops", {31'b0, irq}, 0);

    // R4 R5 R8: gen1 via line 2 forces output 2 low, irq disabled for gen1
    @(negedge clk); flt_in = 4'b0100; edges(3);
    chk("R5 gen1 forced low", {28'b0, pwm_pin}, 32'hA);
    chk("R4 gen1 status", {24'b0, fault_sts}, 32'h40);
    edges(2);
    chk("R8 gen1 irq gated", {31'b0, irq}, 0);
    wr(5'd4, 4'b0010); edges(1);
    chk("R8 gen1 irq enabled", {31'b0, irq}, 1);
    // R2 on forced output
    wr(5'd1, 4'b0100); edges(0);
    @(posedge clk); #1;
    chk("R2 inverts forced", {28'b0, pwm_pin}, 32'hE);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule